// File: doc/BRIEF.md
# Strided DMA Word-Address Generator

This block produces the memory addresses for one DMA channel that walks a rectangular window inside a larger bitmap. Software sets up three things through a narrow register port: a live pointer, a start location, and a signed line modulo. The 20-bit values are each loaded as two 16-bit halves. The DMA engine then pulses `fetch` once for every word it moves. It raises `line_end` with the last fetch of a row, and it pulses `restart` at frame boundaries. The block has no bus, arbitration or data path. It only keeps the address.

Each fetch moves the pointer forward by one 16-bit word. The last fetch of a row also adds the sign-extended modulo, so the next row starts at the correct place in the larger image. A length counter gives a second way to rewind. The counter is reloaded on every restart and counts fetches down. When it runs out, the block pulses `done` and copies the start location back into the pointer. A build-time option limits the pointer and location to 18 significant bits, for narrow memory maps.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the pointer, location, modulo, length register and fetch count are zero, so `addr` reads 0 and `done` is low.
- R2: A register write with `wr_sel`=0 loads word-pointer bits 19:15 from `wr_data[4:0]`. A write with `wr_sel`=1 loads word-pointer bits 14:0 from `wr_data[15:1]`, and `wr_data[0]` is ignored. Codes 2 and 3 load the location register the same way. `addr` is the byte address: the word pointer followed by a constant 0 bit.
- R3: A `fetch` without `line_end` raises `addr` by 2 on the next cycle.
- R4: A `fetch` with `line_end` adds one word plus the modulo. The modulo is written with `wr_sel`=4 from `wr_data[15:1]`, and bit 15 is the sign. A `line_end` without `fetch` has no effect.
- R5: A pulse on `restart`, or a write with `wr_sel`=6 whose data is ignored, copies the location into the pointer and reloads the fetch count from the length register. The length register is written with `wr_sel`=5. The new value appears on `addr` in the next cycle.
- R6: A non-zero fetch count drops by one on each fetch. The fetch that takes it from 1 to 0 raises `done` for exactly the next cycle. At the end of that cycle the pointer reloads from the location and the count reloads; a `fetch` in that cycle is dropped. A count of zero never expires.
- R7: A pointer-half write wins over an advance or reload in the same cycle. The other half keeps its current value.
- R8: Pointer arithmetic wraps modulo 2^20 words with no flag.
- R9: With the 18-bit option, word-pointer bits 19:18 of both pointer and location are always zero, and arithmetic wraps modulo 2^18.
- R10: A write with `wr_sel`=7 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code (see R2, R4, R5, R10) |
| wr_data | input | 16 | Register write data |
| fetch | input | 1 | One word transferred; advance the pointer |
| line_end | input | 1 | Qualifies a fetch as the last word of a row |
| restart | input | 1 | Frame restart event |
| addr | output | 21 | Current byte address, bit 0 always 0 |
| done | output | 1 | One-cycle pulse when the fetch count expires |

## Verification
The bench builds two instances from the same stimulus. One uses the default full 20-bit pointer, where the upper word bits and the wrap at 2^20 can be reached. The other uses the 18-bit option, where masking of high-half writes and the earlier wrap at 2^18 are visible at the same time. The length register is kept small in the random phase, so count expiry, dropped fetches during `done`, and collisions between writes, restarts and advances all happen often.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;

   typedef enum logic [2:0] {
      SEL_PTR_HI  = 3'd0,
      SEL_PTR_LO  = 3'd1,
      SEL_LOC_HI  = 3'd2,
      SEL_LOC_LO  = 3'd3,
      SEL_MOD     = 3'd4,
      SEL_LEN     = 3'd5,
      SEL_RESTART = 3'd6,
      SEL_NONE    = 3'd7
   } agen_sel_e;

endpackage

// File: rtl/dma_agen_regs.sv
module dma_agen_regs
   import dma_agen_pkg::*;
#(
   parameter int PTR_W = 20,
   parameter int REG_W = 16,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic [PTR_W-1:0] keep,
   output logic [PTR_W-1:0] loc,
   output logic [REG_W-2:0] modv,
   output logic [LEN_W-1:0] len,
   output logic             strobe,
   output logic             ptr_wr_hi,
   output logic             ptr_wr_lo
);

   localparam int LO_W = REG_W - 1;
   localparam int HI_W = PTR_W - LO_W;

   agen_sel_e sel;
   assign sel = agen_sel_e'(wr_sel);

   assign strobe    = wr_en && (sel == SEL_RESTART);
   assign ptr_wr_hi = wr_en && (sel == SEL_PTR_HI);
   assign ptr_wr_lo = wr_en && (sel == SEL_PTR_LO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc  <= '0;
         modv <= '0;
         len  <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_LOC_HI: loc  <= {wr_data[HI_W-1:0], loc[LO_W-1:0]} & keep;
            SEL_LOC_LO: loc  <= {loc[PTR_W-1:LO_W], wr_data[REG_W-1:1]} & keep;
            SEL_MOD:    modv <= wr_data[REG_W-1:1];
            SEL_LEN:    len  <= wr_data[LEN_W-1:0];
            default: ;
         endcase
      end
   end

   // R10
   ignored_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd7) |=> ($stable(loc) && $stable(modv) && $stable(len)));

endmodule

// File: rtl/dma_agen_ptr.sv
module dma_agen_ptr #(
   parameter int PTR_W = 20,
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_wr_hi,
   input  logic             ptr_wr_lo,
   input  logic [REG_W-1:0] wr_data,
   input  logic             reload,
   input  logic             fetch,
   input  logic             line_end,
   input  logic [PTR_W-1:0] loc,
   input  logic [REG_W-2:0] modv,
   input  logic [PTR_W-1:0] keep,
   output logic [PTR_W-1:0] wptr
);

   localparam int LO_W  = REG_W - 1;
   localparam int HI_W  = PTR_W - LO_W;
   localparam int EXT_W = PTR_W - LO_W;

   logic [PTR_W-1:0] mod_ext;
   logic [PTR_W-1:0] step;
   logic [PTR_W-1:0] nxt;

   assign mod_ext = {{EXT_W{modv[LO_W-1]}}, modv};
   assign step    = line_end ? (mod_ext + PTR_W'(1)) : PTR_W'(1);

   always_comb begin
      nxt = wptr;
      if (ptr_wr_hi)
         nxt = {wr_data[HI_W-1:0], wptr[LO_W-1:0]};
      else if (ptr_wr_lo)
         nxt = {wptr[PTR_W-1:LO_W], wr_data[REG_W-1:1]};
      else if (reload)
         nxt = loc;
      else if (fetch)
         nxt = wptr + step;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wptr <= '0;
      else        wptr <= nxt & keep;
   end

   // R3
   word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch && !line_end && !reload && !ptr_wr_hi && !ptr_wr_lo)
      |=> wptr == (($past(wptr) + PTR_W'(1)) & keep));

   // R5
   reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !ptr_wr_hi && !ptr_wr_lo) |=> wptr == $past(loc));

   // R7
   hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr_hi |=> wptr[LO_W-1:0] == $past(wptr[LO_W-1:0]));

endmodule

// File: rtl/dma_agen_len.sv
module dma_agen_len #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_any,
   input  logic             fetch,
   input  logic [LEN_W-1:0] len,
   output logic             done
);

   logic [LEN_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (restart_any || done) begin
         cnt  <= len;
         done <= 1'b0;
      end else if (fetch && cnt != '0) begin
         cnt  <= cnt - LEN_W'(1);
         done <= (cnt == LEN_W'(1));
      end else begin
         done <= 1'b0;
      end
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(fetch));

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
   parameter int PTR_W  = 20,
   parameter int REG_W  = 16,
   parameter int LEN_W  = 16,
   parameter bit NARROW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             fetch,
   input  logic             line_end,
   input  logic             restart,
   output logic [PTR_W:0]   addr,
   output logic             done
);

   localparam int LO_W = REG_W - 1;
   localparam int HI_W = PTR_W - LO_W;

   if (HI_W < 1 || HI_W > REG_W) begin : g_bad_ptr_w
      $error("PTR_W must leave a high half of 1..REG_W bits");
   end
   if (LEN_W < 1 || LEN_W > REG_W) begin : g_bad_len_w
      $error("LEN_W must fit in one register write");
   end
   if (NARROW && PTR_W < LO_W + 3) begin : g_bad_narrow
      $error("narrow option needs at least three high bits");
   end

   logic [PTR_W-1:0] keep;
   if (NARROW) begin : g_keep_narrow
      assign keep = {2'b00, {(PTR_W-2){1'b1}}};
   end else begin : g_keep_full
      assign keep = '1;
   end

   logic [PTR_W-1:0] loc;
   logic [PTR_W-1:0] wptr;
   logic [REG_W-2:0] modv;
   logic [LEN_W-1:0] len;
   logic             strobe;
   logic             ptr_wr_hi;
   logic             ptr_wr_lo;
   logic             restart_any;
   logic             reload;

   assign restart_any = restart || strobe;
   assign reload      = restart_any || done;
   assign addr        = {wptr, 1'b0};

   dma_agen_regs #(.PTR_W(PTR_W), .REG_W(REG_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .keep(keep), .loc(loc), .modv(modv), .len(len),
      .strobe(strobe), .ptr_wr_hi(ptr_wr_hi), .ptr_wr_lo(ptr_wr_lo)
   );

   dma_agen_ptr #(.PTR_W(PTR_W), .REG_W(REG_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ptr_wr_hi(ptr_wr_hi), .ptr_wr_lo(ptr_wr_lo),
      .wr_data(wr_data), .reload(reload), .fetch(fetch), .line_end(line_end),
      .loc(loc), .modv(modv), .keep(keep), .wptr(wptr)
   );

   dma_agen_len #(.LEN_W(LEN_W)) u_len (
      .clk(clk), .rst_n(rst_n), .restart_any(restart_any), .fetch(fetch),
      .len(len), .done(done)
   );

   if (NARROW) begin : g_narrow_chk
      // R9
      narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
         addr[PTR_W -: 2] == 2'b00);
   end

   // R4
   lone_line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && !fetch && !reload && !ptr_wr_hi && !ptr_wr_lo) |=> $stable(addr));

endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = 3'd0;
   logic [15:0] wr_data = 16'h0;
   logic        fetch = 1'b0;
   logic        line_end = 1'b0;
   logic        restart = 1'b0;
   logic [20:0] addr_f, addr_n;
   logic        done_f, done_n;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .fetch(fetch), .line_end(line_end), .restart(restart), .addr(addr_f), .done(done_f)
   );

   dma_addr_gen #(.NARROW(1'b1)) u_dut18 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .fetch(fetch), .line_end(line_end), .restart(restart), .addr(addr_n), .done(done_n)
   );

   // reference model, index 0 = full width, 1 = 18-bit option
   logic [19:0] m_ptr [2];
   logic [19:0] m_loc [2];
   logic [19:0] m_keep[2];
   logic [14:0] m_mod [2];
   logic [15:0] m_len [2];
   logic [15:0] m_cnt [2];
   logic        m_done[2];

   function automatic logic [19:0] sext_mod(input logic [14:0] m);
      return {{5{m[14]}}, m};
   endfunction

   task automatic model_reset();
      for (int v = 0; v < 2; v++) begin
         m_ptr[v] = '0; m_loc[v] = '0; m_mod[v] = '0;
         m_len[v] = '0; m_cnt[v] = '0; m_done[v] = 1'b0;
      end
      m_keep[0] = 20'hFFFFF;
      m_keep[1] = 20'h3FFFF;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [20:0] act, input logic [20:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check(tag, "addr full", addr_f, {m_ptr[0], 1'b0});
      check(tag, "done full", {20'h0, done_f}, {20'h0, m_done[0]});
      check(tag, "addr narrow", addr_n, {m_ptr[1], 1'b0});
      check(tag, "done narrow", {20'h0, done_n}, {20'h0, m_done[1]});
   endtask

   task automatic step(input logic we, input logic [2:0] sel, input logic [15:0] d,
                       input logic f, input logic le, input logic rs, input string tag);
      logic [19:0] np[2]; logic [19:0] nl[2]; logic [14:0] nm[2];
      logic [15:0] nn[2]; logic [15:0] nc[2]; logic nd[2];
      logic rl;
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = d; fetch = f; line_end = le; restart = rs;
      for (int v = 0; v < 2; v++) begin
         rl = rs || (we && sel == 3'd6) || m_done[v];
         np[v] = m_ptr[v]; nl[v] = m_loc[v]; nm[v] = m_mod[v]; nn[v] = m_len[v];
         if (we && sel == 3'd0)      np[v] = {d[4:0], m_ptr[v][14:0]};
         else if (we && sel == 3'd1) np[v] = {m_ptr[v][19:15], d[15:1]};
         else if (rl)                np[v] = m_loc[v];
         else if (f)                 np[v] = m_ptr[v] + 20'd1 + (le ? sext_mod(m_mod[v]) : 20'd0);
         np[v] &= m_keep[v];
         if (we && sel == 3'd2) nl[v] = {d[4:0], m_loc[v][14:0]} & m_keep[v];
         if (we && sel == 3'd3) nl[v] = {m_loc[v][19:15], d[15:1]} & m_keep[v];
         if (we && sel == 3'd4) nm[v] = d[15:1];
         if (we && sel == 3'd5) nn[v] = d;
         nd[v] = 1'b0; nc[v] = m_cnt[v];
         if (rl) nc[v] = m_len[v];
         else if (f && m_cnt[v] != 0) begin
            nc[v] = m_cnt[v] - 16'd1;
            nd[v] = (m_cnt[v] == 16'd1);
         end
      end
      @(posedge clk);
      #1;
      for (int v = 0; v < 2; v++) begin
         m_ptr[v] = np[v]; m_loc[v] = nl[v]; m_mod[v] = nm[v];
         m_len[v] = nn[v]; m_cnt[v] = nc[v]; m_done[v] = nd[v];
      end
      compare(tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 1'b0, tag);
   endtask

   function automatic string rand_tag(input logic we, input logic [2:0] sel,
                                      input logic f, input logic le, input logic rs);
      if (we && sel <= 3'd1) return (f || rs) ? "R7" : "R2";
      if (rs || (we && sel == 3'd6)) return "R5";
      if (m_done[0] || m_done[1]) return "R6";
      if (we && sel == 3'd7) return "R10";
      if (f && le) return "R4";
      if (f) return "R3";
      return "R8";
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      logic        we, f, le, rs;
      logic [2:0]  sel;
      logic [15:0] d;
      model_reset();
      r = $urandom(32'd20240611);
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1 compare("R1");

      // R2: pointer halves, data bit 0 of the low half ignored
      step(1'b1, 3'd0, 16'h0013, 1'b0, 1'b0, 1'b0, "R2");
      step(1'b1, 3'd1, 16'hABCD, 1'b0, 1'b0, 1'b0, "R2");
      // R3: plain word advances
      repeat (3) step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 1'b0, "R3");
      // R4: negative and positive modulo, lone line_end
      step(1'b1, 3'd4, 16'hFFF8, 1'b0, 1'b0, 1'b0, "R4");
      step(1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R4");
      step(1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 1'b0, "R4");
      step(1'b1, 3'd4, 16'h0020, 1'b0, 1'b0, 1'b0, "R4");
      step(1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R4");
      // R5: location, restart input and strobe write
      step(1'b1, 3'd2, 16'h0001, 1'b0, 1'b0, 1'b0, "R5");
      step(1'b1, 3'd3, 16'h2000, 1'b0, 1'b0, 1'b0, "R5");
      step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 1'b1, "R5");
      step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 1'b0, "R5");
      step(1'b1, 3'd6, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R5");
      // R6: count expiry, fetch dropped during done, zero length never expires
      step(1'b1, 3'd5, 16'h0003, 1'b0, 1'b0, 1'b0, "R6");
      step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 1'b1, "R6");
      repeat (3) step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 1'b0, "R6");
      step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 1'b0, "R6");
      idle("R6");
      step(1'b1, 3'd5, 16'h0000, 1'b0, 1'b0, 1'b1, "R6");
      step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 1'b1, "R6");
      repeat (5) step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 1'b0, "R6");
      // R7: pointer write against advance and reload
      step(1'b1, 3'd1, 16'h1234, 1'b1, 1'b1, 1'b0, "R7");
      step(1'b1, 3'd0, 16'h0005, 1'b0, 1'b0, 1'b1, "R7");
      // R8 / R9: top-of-range wrap and narrow masking
      step(1'b1, 3'd0, 16'h001F, 1'b0, 1'b0, 1'b0, "R9");
      step(1'b1, 3'd1, 16'hFFFE, 1'b0, 1'b0, 1'b0, "R9");
      step(1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 1'b0, "R8");
      step(1'b1, 3'd4, 16'hFFFE, 1'b0, 1'b0, 1'b0, "R8");
      step(1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R8");
      step(1'b1, 3'd4, 16'hFFFC, 1'b0, 1'b0, 1'b0, "R8");
      step(1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R8");
      // R10: unused code leaves modulo, location and length alone
      step(1'b1, 3'd7, 16'h5555, 1'b0, 1'b0, 1'b0, "R10");
      step(1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R10");
      step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 1'b1, "R10");

      // random phase, short lengths so expiry is frequent
      for (int i = 0; i < 4000; i++) begin
         r   = $urandom;
         we  = (r[3:0] < 4'd4);
         sel = r[6:4];
         d   = $urandom;
         if (we && sel == 3'd5) d = {12'h0, d[3:0]};
         f   = r[8] | r[9];
         le  = (r[12:10] == 3'd0);
         rs  = (r[17:13] == 5'd0);
         step(we, sel, d, f, le, rs, rand_tag(we, sel, f, le, rs));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule